// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers the four shared PCI interrupt request lines onto a sixteen-line input bus of a legacy interrupt controller. Each PCI line has its own routing byte that holds the number of the controller line it drives. A byte of sixteen or more leaves that PCI line unconnected. Each controller line is level-sensitive and is high while any PCI line steered to it is asserted, so several PCI lines can share one controller line.

The routing bytes are loaded through a simple write port. The port takes a byte offset, a 32-bit data word and four byte enables. Internally the block keeps a level map with one bit for each pair of controller line and PCI line. The map is rebuilt every clock from the live PCI levels and the current routing, so a change of routing takes effect at once, without stale bits from the old route. A separate combinational helper gives the PCI line that a device's INTx pin lands on, based on the device's slot number.

Top module: `pirq_router`

## Requirements
- R1: Controller line n (0 to 15) is high exactly when at least one PCI line whose routing byte equals n is asserted. Several PCI lines may share one controller line.
- R2: A write whose offset, with its two low bits cleared, equals 0x60 updates routing byte k (k = 0 for line A up to k = 3 for line D) from data bits [8k+7:8k], but only where byte enable k is set. Byte lanes whose enable is clear keep their old value.
- R3: A routing byte of 16 or more, such as 0x10, 0x80 or 0xFF, disconnects its PCI line, which then drives no controller line.
- R4: A synchronous reset sets all four routing bytes to 0x80 and clears the level map, so every controller line is low during reset and after it.
- R5: Writes to any dword other than the one at 0x60, for example offset 0x64, leave the routing unchanged. The two low offset bits do not select a lane, so offset 0x61 addresses the same dword as 0x60.
- R6: A change of a PCI line level shows on the controller lines one clock after it is sampled.
- R7: A routing write moves a line's contribution to its new controller line one clock after the write is sampled. At the same moment the old controller line drops, unless another PCI line still holds it. This also applies when a line level changes in the same cycle as the write.
- R8: The helper output swz_line_o equals (swz_pin_i + swz_slot_i − 1) mod 4, combinationally, for INTx pins 0 to 3 and any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pci_line_i | input | 4 | Live PCI interrupt levels, bit 0 = line A |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_off_i | input | 8 | Byte offset of the write |
| cfg_wdata_i | input | 32 | Write data, byte lane k in bits [8k+7:8k] |
| cfg_be_i | input | 4 | Byte enables, one per lane |
| swz_pin_i | input | 2 | Device INTx pin, 0 = INTA |
| swz_slot_i | input | 5 | Device slot number |
| swz_line_o | output | 2 | PCI line reached by that pin |
| irq_o | output | 16 | Level-sensitive controller lines |

## Verification
The hardest case to reach from the ports is a routing rewrite in the same cycle as a PCI level change, while another line shares the old target. The outputs are correct only if the map is rebuilt from the new routing together with the new levels, and the shared target stays up. The stimulus first sets up two lines on one target and holds them high. It then issues a single-lane write that moves one of them and, in the same cycle, toggles the other, so that both the drop and the hold show on one sampled edge. Partial byte-enable writes and writes to the neighbouring dword are mixed in, so that an ignored write would show as a wrong output.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int NLINES  = 4;
    localparam int ROUTE_W = 8;
    localparam int LANES   = 4;
    localparam int DATA_W  = LANES * 8;

    typedef logic [ROUTE_W-1:0]             route_t;
    typedef logic [NLINES-1:0][ROUTE_W-1:0] route_vec_t;

    localparam route_t ROUTE_RST = 8'h80;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_pkg::*;
#(
    parameter logic [7:0] BASE = 8'h60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [7:0]        off_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  be_i,
    output route_vec_t        route_d_o,
    output route_vec_t        route_q_o
);
    typedef struct packed {
        route_vec_t route;
    } regs_t;

    regs_t st_d, st_q;
    logic  hit;

    always_comb begin
        st_d = st_q;
        hit  = wr_i && ((off_i & 8'hFC) == (BASE & 8'hFC));
        for (int k = 0; k < NLINES; k++) begin
            if (hit && be_i[k]) begin
                st_d.route[k] = wdata_i[8*k +: 8];
            end
        end
        if (rst) begin
            for (int k = 0; k < NLINES; k++) begin
                st_d.route[k] = ROUTE_RST;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign route_d_o = st_d.route;
    assign route_q_o = st_q.route;

    // R5
    cfg_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_i && ((off_i & 8'hFC) != (BASE & 8'hFC))) |=> $stable(route_q_o));

    // R4
    route_rst_chk: assert property (@(posedge clk)
        rst |=> (route_q_o == {NLINES{ROUTE_RST}}));
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
    import pirq_pkg::*;
#(
    parameter int NOUT = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  route_vec_t             route_i,
    input  logic [NLINES-1:0]      line_i,
    output logic [NOUT*NLINES-1:0] map_q_o
);
    localparam int OW    = $clog2(NOUT);
    localparam int MAP_W = NOUT * NLINES;

    typedef struct packed {
        logic [MAP_W-1:0] map;
    } lvl_t;

    lvl_t st_d, st_q;

    always_comb begin
        st_d.map = '0;
        for (int p = 0; p < NLINES; p++) begin
            if (route_i[p] < ROUTE_W'(NOUT)) begin
                st_d.map[int'(route_i[p][OW-1:0]) * NLINES + p] = line_i[p];
            end
        end
        if (rst) begin
            st_d.map = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign map_q_o = st_q.map;

    // R4
    map_rst_chk: assert property (@(posedge clk)
        rst |=> (map_q_o == '0));
endmodule

// File: rtl/pirq_or_reduce.sv
module pirq_or_reduce
    import pirq_pkg::*;
#(
    parameter int NOUT = 16
) (
    input  logic [NOUT*NLINES-1:0] map_i,
    output logic [NOUT-1:0]        irq_o
);
    for (genvar c = 0; c < NOUT; c++) begin : g_out
        assign irq_o[c] = |map_i[c*NLINES +: NLINES];
    end
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
    parameter int SLOT_W = 5
) (
    input  logic [1:0]        pin_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [1:0]        line_o
);
    logic [SLOT_W+1:0] sum;

    always_comb begin
        sum    = (SLOT_W+2)'(pin_i) + (SLOT_W+2)'(slot_i) + (SLOT_W+2)'(3);
        line_o = 2'(sum);
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int         NUM_OUTS   = 16,
    parameter int         SLOT_W     = 5,
    parameter logic [7:0] ROUTE_BASE = 8'h60
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          pci_line_i,
    input  logic                cfg_wr_i,
    input  logic [7:0]          cfg_off_i,
    input  logic [31:0]         cfg_wdata_i,
    input  logic [3:0]          cfg_be_i,
    input  logic [1:0]          swz_pin_i,
    input  logic [SLOT_W-1:0]   swz_slot_i,
    output logic [1:0]          swz_line_o,
    output logic [NUM_OUTS-1:0] irq_o
);
    localparam int OW = $clog2(NUM_OUTS);

    route_vec_t                  route_d, route_q;
    logic [NUM_OUTS*NLINES-1:0]  map_q;

    pirq_route_regs #(.BASE(ROUTE_BASE)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (cfg_wr_i),
        .off_i     (cfg_off_i),
        .wdata_i   (cfg_wdata_i),
        .be_i      (cfg_be_i),
        .route_d_o (route_d),
        .route_q_o (route_q)
    );

    pirq_level_map #(.NOUT(NUM_OUTS)) u_map (
        .clk     (clk),
        .rst     (rst),
        .route_i (route_d),
        .line_i  (pci_line_i),
        .map_q_o (map_q)
    );

    pirq_or_reduce #(.NOUT(NUM_OUTS)) u_or (
        .map_i (map_q),
        .irq_o (irq_o)
    );

    pirq_swizzle #(.SLOT_W(SLOT_W)) u_swz (
        .pin_i  (swz_pin_i),
        .slot_i (swz_slot_i),
        .line_o (swz_line_o)
    );

    // R3
    off_route_chk: assert property (@(posedge clk) disable iff (rst)
        (route_d[0] >= 8'(NUM_OUTS) && route_d[1] >= 8'(NUM_OUTS) &&
         route_d[2] >= 8'(NUM_OUTS) && route_d[3] >= 8'(NUM_OUTS)) |=> (irq_o == '0));

    // R1
    fanin_bound_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(irq_o) <= $countones($past(pci_line_i))));

    for (genvar p = 0; p < NLINES; p++) begin : g_trk
        // R6
        line_track_chk: assert property (@(posedge clk) disable iff (rst)
            (!cfg_wr_i && route_q[p] < 8'(NUM_OUTS) && pci_line_i[p])
            |=> irq_o[$past(route_q[p][OW-1:0])]);
    end
endmodule

// File: tb/pirq_router_bench.sv
module pirq_router_bench;
    typedef struct {
        logic [15:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  pci_line_i = '0;
    logic        cfg_wr_i = 1'b0;
    logic [7:0]  cfg_off_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic [3:0]  cfg_be_i = '0;
    logic [1:0]  swz_pin_i = '0;
    logic [4:0]  swz_slot_i = '0;
    logic [1:0]  swz_line_o;
    logic [15:0] irq_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    item_t q[$];
    logic [7:0] mroute [4];

    always #2 clk = ~clk;

    pirq_router u_pirq_router (
        .clk         (clk),
        .rst         (rst),
        .pci_line_i  (pci_line_i),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_off_i   (cfg_off_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cfg_be_i    (cfg_be_i),
        .swz_pin_i   (swz_pin_i),
        .swz_slot_i  (swz_slot_i),
        .swz_line_o  (swz_line_o),
        .irq_o       (irq_o)
    );

    function automatic logic [15:0] model_irq(input logic [3:0] ln);
        logic [15:0] r = '0;
        for (int p = 0; p < 4; p++) begin
            if (ln[p] && mroute[p] < 8'd16) r[mroute[p][3:0]] = 1'b1;
        end
        return r;
    endfunction

    task automatic step(input logic r, input logic [3:0] ln, input logic wr,
                        input logic [7:0] off, input logic [31:0] d,
                        input logic [3:0] be, input string req);
        item_t it;
        @(negedge clk);
        rst = r; pci_line_i = ln; cfg_wr_i = wr;
        cfg_off_i = off; cfg_wdata_i = d; cfg_be_i = be;
        if (r) begin
            for (int k = 0; k < 4; k++) mroute[k] = 8'h80;
            it.exp = '0;
        end else begin
            if (wr && ((off & 8'hFC) == 8'h60)) begin
                for (int k = 0; k < 4; k++) if (be[k]) mroute[k] = d[8*k +: 8];
            end
            it.exp = model_irq(ln);
        end
        it.req = req;
        q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                n_tests++;
                if (irq_o !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s irq_o actual=%h expected=%h", it.req, irq_o, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : driver
        for (int k = 0; k < 4; k++) mroute[k] = 8'h80;
        // R4: in reset and right after, all lines high but all disconnected
        step(1, 4'hF, 0, 8'h00, 0, 4'h0, "R4");
        step(1, 4'hF, 0, 8'h00, 0, 4'h0, "R4");
        step(0, 4'hF, 0, 8'h00, 0, 4'h0, "R4");
        step(0, 4'hF, 0, 8'h00, 0, 4'h0, "R3");
        // R2: A->3, B->5, C->3, D->15 in one full write; R1 sharing on 3
        step(0, 4'hF, 1, 8'h60, 32'h0F03_0503, 4'hF, "R2");
        step(0, 4'h1, 0, 8'h00, 0, 4'h0, "R6");
        step(0, 4'h4, 0, 8'h00, 0, 4'h0, "R1");
        step(0, 4'h5, 0, 8'h00, 0, 4'h0, "R1");
        step(0, 4'h2, 0, 8'h00, 0, 4'h0, "R6");
        step(0, 4'h8, 0, 8'h00, 0, 4'h0, "R6");
        step(0, 4'h0, 0, 8'h00, 0, 4'h0, "R6");
        // R2: lane 1 only (B->7), other lanes carry junk that must not land
        step(0, 4'hF, 1, 8'h60, 32'hAAAA_07BB, 4'h2, "R2");
        step(0, 4'hF, 0, 8'h00, 0, 4'h0, "R2");
        // R5: neighbouring dword ignored
        step(0, 4'hF, 1, 8'h64, 32'h0000_0000, 4'hF, "R5");
        step(0, 4'hF, 0, 8'h00, 0, 4'h0, "R5");
        // R5: zero byte enables ignored
        step(0, 4'hF, 1, 8'h60, 32'h0101_0101, 4'h0, "R5");
        // R5: low offset bits do not pick a lane (D->12 via 0x61)
        step(0, 4'hF, 1, 8'h61, 32'h0C00_0000, 4'h8, "R5");
        // R3: disconnect values
        step(0, 4'hF, 1, 8'h60, 32'h0000_1000, 4'h2, "R3");
        step(0, 4'hF, 1, 8'h60, 32'hFF00_0000, 4'h8, "R3");
        step(0, 4'hF, 1, 8'h60, 32'h0000_0080, 4'h1, "R3");
        // R7: set A->9, C->9, both high; move A->11 while C drops same cycle
        step(0, 4'h5, 1, 8'h60, 32'h0009_0009, 4'h5, "R7");
        step(0, 4'h1, 1, 8'h60, 32'h0000_000B, 4'h1, "R7");
        // R7: move A back to 9 while C rises: 9 held by both, 11 drops
        step(0, 4'h5, 1, 8'h60, 32'h0000_0009, 4'h1, "R7");
        step(0, 4'h4, 1, 8'h60, 32'h0000_000E, 4'h1, "R7");
        // R4: reset mid-run restores disconnected state
        step(1, 4'hF, 0, 8'h00, 0, 4'h0, "R4");
        step(0, 4'hF, 0, 8'h00, 0, 4'h0, "R4");
        step(0, 4'h0, 0, 8'h00, 0, 4'h0, "R4");
        repeat (3) @(negedge clk);

        // R8: swizzle sweep
        for (int s = 0; s < 32; s += 3) begin
            for (int p = 0; p < 4; p++) begin
                @(negedge clk);
                swz_pin_i = 2'(p);
                swz_slot_i = 5'(s);
                #1;
                n_tests++;
                if (swz_line_o !== 2'((p + s + 3) % 4)) begin
                    n_fail++;
                    $display("FAIL R8 swz_line_o actual=%0d expected=%0d",
                             swz_line_o, (p + s + 3) % 4);
                end
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule